// File: doc/BRIEF.md
# Indexed Link Register Window

This block is a 16-byte register window. Through it a host reaches the serial-link status, control and error registers of four device slots, using an index word and a data word. The host first writes the index word. The index names a slot and one of that slot's registers. The host then reads or writes the data word, and that access goes to the named register. The index keeps its value until the host writes it again, so a run of data accesses all go to the same register.

A slot number is the port number times two plus the device number: 0 for the first device on a port, 1 for the second. There are two ports with two devices each, so slots run from 0 to 3. Each slot's status register shows its link-state input word as it is on that cycle. The control register is a plain read/write word. The error register collects error-event inputs, and each bit stays set until the host clears it.

The host port is a simple register bus with no back-pressure. A write (`bus_wr`) or a read (`bus_rd`) is accepted on any cycle. Read data comes back registered, on the cycle after the request, and `bus_rvalid` marks it. Read data is valid for one cycle only, and the host must take it then. The host raises only one of `bus_wr` and `bus_rd` in a given cycle.

Top module: `lnkwin_top`

## Requirements
- R1: After reset the index word, every control register and every error register are zero, and `bus_rvalid` and `bus_rdata` are low.
- R2: A write to byte offset 0 loads the full 32-bit index word. A read of offset 0 returns that word. The index holds its value through any number of data accesses until offset 0 is written again.
- R3: A read of byte offset 4 returns the register named by the index. Index bits [15:8] are the slot number (port*2 + device). Index bits [7:0] are the selector: 0 is status, 1 is control, 2 is error. A status read returns the slot's link-state input word as sampled on the read cycle.
- R4: A write to offset 4 with selector 1 stores all 32 bits into the named slot's control register. No other slot's registers change.
- R5: The status register is read-only. A data write with selector 0 changes no stored state.
- R6: Each error bit is set by a high bit on that slot's error-event input and stays set. Writing 1 to a bit through the data word with selector 2 clears that bit. Writing 0 leaves the bit as it is. If an event and a clear hit the same bit in the same cycle, the bit ends up set.
- R7: If the selector is above 2 or the slot number is above 3, a data read returns zero and a data write changes nothing.
- R8: `bus_rvalid` is high exactly on the cycle after each `bus_rd` and low otherwise. Reads of offsets 8 and 12 return zero. Writes to offsets 8 and 12 change nothing. Address bits [1:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_rd | input | 1 | Read strobe, one word per cycle |
| bus_addr | input | 4 | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rvalid is high |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| link_status_i | input | 128 | Link-state word for each slot, slot s at bits [32s+31:32s] |
| err_event_i | input | 128 | Error-event pulses for each slot, same packing |

## Verification
The bench aims at the index fields that are out of range. If the slot field were truncated instead of range-checked, slot 4 would alias slot 0, and writing to it would corrupt slot 0's control register. The bench also tests a clear and an event hitting the same error bit in one cycle. A design that gives the clear priority there loses an error. It also checks that a write with the status selector is dropped and that the unused offsets leave the index alone. A faulty decode on either would overwrite the index or a control register. Finally, the bench confirms that each slot's control and error registers stay separate, and that the index holds across repeated data reads.

// File: rtl/lnkwin_pkg.sv
package lnkwin_pkg;
  // byte-address width of the 16-byte window
  localparam int unsigned WIN_AW = 4;
  // number of selectable registers per slot
  localparam int unsigned NUM_SEL = 3;
  // word offsets inside the window
  localparam logic [1:0] WORD_INDEX = 2'd0;
  localparam logic [1:0] WORD_DATA  = 2'd1;
  // bit positions of the index fields
  localparam int unsigned SEL_LSB  = 0;
  localparam int unsigned SLOT_LSB = 8;
  localparam int unsigned FIELD_W  = 8;

  typedef enum logic [1:0] {
    SEL_STATUS  = 2'd0,
    SEL_CONTROL = 2'd1,
    SEL_ERROR   = 2'd2,
    SEL_NONE    = 2'd3
  } lreg_sel_e;
endpackage

// File: rtl/lnkwin_index.sv
module lnkwin_index
  import lnkwin_pkg::*;
#(
  parameter int unsigned DW     = 32,
  parameter int unsigned NSLOT  = 4,
  parameter int unsigned SLOT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idx_we,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     idx_q,
  output logic [SLOT_W-1:0] slot_o,
  output lreg_sel_e         sel_o,
  output logic              hit_o
);
  logic [FIELD_W-1:0] slot_field;
  logic [FIELD_W-1:0] sel_field;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_we) idx_q <= wdata;
  end

  assign slot_field = idx_q[SLOT_LSB +: FIELD_W];
  assign sel_field  = idx_q[SEL_LSB +: FIELD_W];
  assign slot_o     = slot_field[SLOT_W-1:0];

  always_comb begin
    hit_o = (int'(slot_field) < int'(NSLOT)) && (int'(sel_field) < int'(NUM_SEL));
    sel_o = hit_o ? lreg_sel_e'(sel_field[1:0]) : SEL_NONE;
  end

  AST_INDEX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_we |=> $stable(idx_q)); // R2
  AST_INDEX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    idx_we |=> (idx_q == $past(wdata))); // R2
endmodule

// File: rtl/lnkwin_slot.sv
module lnkwin_slot #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_we,
  input  logic          err_clr_we,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] err_evt,
  output logic [DW-1:0] ctrl_q,
  output logic [DW-1:0] err_q
);
  logic [DW-1:0] clr_mask;

  assign clr_mask = err_clr_we ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= wdata;
  end

  // events are ORed in after the clear, so an event in the clearing cycle wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= '0;
    else        err_q <= (err_q & ~clr_mask) | err_evt;
  end

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_we |=> $stable(ctrl_q)); // R4
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_evt != '0) |=> ((err_q & $past(err_evt)) == $past(err_evt))); // R6
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_clr_we && err_evt == '0) |=> $stable(err_q)); // R6
endmodule

// File: rtl/lnkwin_rdmux.sv
module lnkwin_rdmux
  import lnkwin_pkg::*;
#(
  parameter int unsigned DW     = 32,
  parameter int unsigned NSLOT  = 4,
  parameter int unsigned SLOT_W = 2
) (
  input  logic [1:0]                word,
  input  logic [DW-1:0]             idx_q,
  input  logic                      hit,
  input  logic [SLOT_W-1:0]         slot,
  input  lreg_sel_e                 sel,
  input  logic [NSLOT-1:0][DW-1:0]  status_w,
  input  logic [NSLOT-1:0][DW-1:0]  ctrl_w,
  input  logic [NSLOT-1:0][DW-1:0]  err_w,
  output logic [DW-1:0]             rd_word
);
  always_comb begin
    rd_word = '0;
    if (word == WORD_INDEX) begin
      rd_word = idx_q;
    end else if (word == WORD_DATA && hit) begin
      unique case (sel)
        SEL_STATUS:  rd_word = status_w[slot];
        SEL_CONTROL: rd_word = ctrl_w[slot];
        SEL_ERROR:   rd_word = err_w[slot];
        default:     rd_word = '0;
      endcase
    end
  end
endmodule

// File: rtl/lnkwin_top.sv
module lnkwin_top
  import lnkwin_pkg::*;
#(
  parameter int unsigned NSLOT = 4,
  parameter int unsigned DW    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [WIN_AW-1:0]   bus_addr,
  input  logic [DW-1:0]       bus_wdata,
  output logic [DW-1:0]       bus_rdata,
  output logic                bus_rvalid,
  input  logic [NSLOT*DW-1:0] link_status_i,
  input  logic [NSLOT*DW-1:0] err_event_i
);
  localparam int unsigned SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;

  logic [1:0]               word;
  logic                     idx_we;
  logic                     data_we;
  logic [DW-1:0]            idx_q;
  logic [SLOT_W-1:0]        cur_slot;
  lreg_sel_e                cur_sel;
  logic                     cur_hit;
  logic [NSLOT-1:0][DW-1:0] status_w;
  logic [NSLOT-1:0][DW-1:0] ctrl_w;
  logic [NSLOT-1:0][DW-1:0] err_w;
  logic [DW-1:0]            rd_word;
  logic [DW-1:0]            rdata_q;
  logic                     rvalid_q;

  assign word    = bus_addr[3:2];
  assign idx_we  = bus_wr && (word == WORD_INDEX);
  assign data_we = bus_wr && (word == WORD_DATA) && cur_hit;

  lnkwin_index #(.DW(DW), .NSLOT(NSLOT), .SLOT_W(SLOT_W)) u_index (
    .clk    (clk),
    .rst_n  (rst_n),
    .idx_we (idx_we),
    .wdata  (bus_wdata),
    .idx_q  (idx_q),
    .slot_o (cur_slot),
    .sel_o  (cur_sel),
    .hit_o  (cur_hit)
  );

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic ctrl_we_s;
    logic clr_we_s;
    assign status_w[s] = link_status_i[s*DW +: DW];
    assign ctrl_we_s   = data_we && (cur_sel == SEL_CONTROL) && (int'(cur_slot) == s);
    assign clr_we_s    = data_we && (cur_sel == SEL_ERROR)   && (int'(cur_slot) == s);

    lnkwin_slot #(.DW(DW)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctrl_we    (ctrl_we_s),
      .err_clr_we (clr_we_s),
      .wdata      (bus_wdata),
      .err_evt    (err_event_i[s*DW +: DW]),
      .ctrl_q     (ctrl_w[s]),
      .err_q      (err_w[s])
    );
  end

  lnkwin_rdmux #(.DW(DW), .NSLOT(NSLOT), .SLOT_W(SLOT_W)) u_rdmux (
    .word     (word),
    .idx_q    (idx_q),
    .hit      (cur_hit),
    .slot     (cur_slot),
    .sel      (cur_sel),
    .status_w (status_w),
    .ctrl_w   (ctrl_w),
    .err_w    (err_w),
    .rd_word  (rd_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rdata_q  <= bus_rd ? rd_word : '0;
      rvalid_q <= bus_rd;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;

  AST_RVALID_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid); // R8
  AST_RVALID_ONLY_RD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid); // R8
  AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && word == WORD_DATA && !cur_hit) |=> (bus_rdata == '0)); // R7
  AST_SPARE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && word[1]) |=> (bus_rdata == '0)); // R8
  AST_MISS_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !idx_we && !data_we) |=> ($stable(ctrl_w) && $stable(idx_q))); // R7
endmodule

// File: tb/sim_lnkwin_top.sv
module sim_lnkwin_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_wr = 1'b0;
  logic         bus_rd = 1'b0;
  logic [3:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic         bus_rvalid;
  logic [127:0] link_status = '0;
  logic [127:0] err_ev = '0;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk; // 250 MHz

  lnkwin_top u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_wr        (bus_wr),
    .bus_rd        (bus_rd),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .bus_rvalid    (bus_rvalid),
    .link_status_i (link_status),
    .err_event_i   (err_ev)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] stat_val(input int s);
    return 32'h5A00_0013 | (32'(s) << 8);
  endfunction

  function automatic logic [31:0] idx(input int slot, input int sel);
    return (32'(slot) << 8) | 32'(sel);
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8 unexpected rvalid", bus_rdata, 32'h0);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(bus_rdata === e, t, bus_rdata, e);
      end
    end
  end

  task automatic bwrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bread(input logic [3:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(t);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog expired", 32'h0, 32'h0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 4; s++) link_status[s*32 +: 32] = stat_val(s);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(bus_rvalid === 1'b0, "R1 rvalid in reset", {31'b0, bus_rvalid}, 32'h0);
    chk(bus_rdata === 32'h0, "R1 rdata in reset", bus_rdata, 32'h0);
    rst_n = 1'b1;
    bread(4'h0, 32'h0, "R1 index after reset");
    for (int s = 0; s < 4; s++) begin
      bwrite(4'h0, idx(s, 1));
      bread(4'h4, 32'h0, "R1 control after reset");
      bwrite(4'h0, idx(s, 2));
      bread(4'h4, 32'h0, "R1 error after reset");
    end
    // R3 status per slot
    for (int s = 0; s < 4; s++) begin
      bwrite(4'h0, idx(s, 0));
      bread(4'h4, stat_val(s), "R3 status read");
    end
    // R4 control write per slot, then isolation readback
    for (int s = 0; s < 4; s++) begin
      bwrite(4'h0, idx(s, 1));
      bwrite(4'h4, 32'hC0DE_0000 | 32'(s * 17));
    end
    for (int s = 0; s < 4; s++) begin
      bwrite(4'h0, idx(s, 1));
      bread(4'h4, 32'hC0DE_0000 | 32'(s * 17), "R4 control readback");
    end
    // R5 status write ignored
    bwrite(4'h0, idx(3, 0));
    bwrite(4'h4, 32'hFFFF_FFFF);
    bread(4'h4, stat_val(3), "R5 status after write");
    bwrite(4'h0, idx(3, 1));
    bread(4'h4, 32'hC0DE_0033, "R5 control untouched");
    // R2 index hold over repeated reads
    bwrite(4'h0, idx(2, 1));
    bread(4'h0, idx(2, 1), "R2 index readback");
    bread(4'h4, 32'hC0DE_0022, "R2 first data read");
    bread(4'h4, 32'hC0DE_0022, "R2 repeated data read");
    bread(4'h0, idx(2, 1), "R2 index still held");
    // R6 error sticky and W1C
    @(negedge clk); err_ev[2*32 +: 32] = 32'h0000_0401;
    @(negedge clk); err_ev = '0;
    repeat (2) @(negedge clk);
    bwrite(4'h0, idx(2, 2));
    bread(4'h4, 32'h0000_0401, "R6 sticky error");
    bwrite(4'h0, idx(1, 2));
    bread(4'h4, 32'h0, "R6 other slot clean");
    bwrite(4'h0, idx(2, 2));
    bwrite(4'h4, 32'h0000_0001);
    bread(4'h4, 32'h0000_0400, "R6 write-one clear");
    bwrite(4'h4, 32'h0000_0000);
    bread(4'h4, 32'h0000_0400, "R6 write-zero keeps");
    // R6 event and clear in the same cycle on bit 0, clear only on bit 10
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 4'h4; bus_wdata = 32'h0000_0401;
    err_ev[2*32 +: 32] = 32'h0000_0001;
    @(negedge clk);
    bus_wr = 1'b0; err_ev = '0;
    bread(4'h4, 32'h0000_0001, "R6 event beats clear");
    // R7 bad selector and bad slot
    bwrite(4'h0, idx(1, 3));
    bread(4'h4, 32'h0, "R7 bad selector read");
    bwrite(4'h4, 32'hDEAD_BEEF);
    bwrite(4'h0, idx(4, 1));
    bread(4'h4, 32'h0, "R7 bad slot read");
    bwrite(4'h4, 32'hDEAD_BEEF);
    bwrite(4'h0, idx(4, 2));
    bwrite(4'h4, 32'hFFFF_FFFF);
    for (int s = 0; s < 4; s++) begin
      bwrite(4'h0, idx(s, 1));
      bread(4'h4, 32'hC0DE_0000 | 32'(s * 17), "R7 control unchanged");
    end
    bwrite(4'h0, idx(2, 2));
    bread(4'h4, 32'h0000_0001, "R7 error unchanged");
    // R8 spare offsets and rvalid timing
    bread(4'h8, 32'h0, "R8 offset 8 reads zero");
    bread(4'hC, 32'h0, "R8 offset 12 reads zero");
    bwrite(4'h8, 32'h1234_5678);
    bwrite(4'hC, 32'h1234_5678);
    bread(4'h0, idx(2, 2), "R8 index unchanged by spare write");
    bread(4'h5, 32'h0000_0001, "R8 low address bits ignored");
    @(negedge clk);
    chk(bus_rvalid === 1'b0, "R8 rvalid low when idle", {31'b0, bus_rvalid}, 32'h0);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R8 all reads answered", 32'(exp_q.size()), 32'h0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule